// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and produces a full product of `2*WIDTH` bits. It works through the multiplier one bit per clock. The design is split into two parts. A data subsystem holds the multiplicand register, the multiplier register, a double-width accumulator and an iteration counter. A control subsystem is a small state machine. It drives a five-bit control word into the datapath and reads a last-iteration condition back from it.

A client waits for `done` to be high. It then presents the operands and pulses `start` for one cycle. It holds the operands through the following cycle, because they are captured at the edge that ends the load state. `done` stays low while the multiply is in progress. When `done` rises again, `product` holds the full result and keeps it until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: After a clock edge with `rst_n` low, `done` is 1 and `product` is 0.
- R2: While idle with `start` low, `done` stays 1 and `product` does not change.
- R3: A `start` seen high at an edge while `done` is 1 is accepted. `done` reads 0 right after that edge.
- R4: The operands are captured from `op_a` and `op_b` at the edge that follows the accepting edge, which is the end of the load state. Their values at any later edge have no effect on the result.
- R5: When `done` returns to 1, `product` equals `op_a * op_b` as an unsigned `2*WIDTH`-bit value.
- R6: `done` returns to 1 exactly `WIDTH+1` edges after the accepting edge: one load state followed by `WIDTH` iteration states.
- R7: While `done` is 1, `product` is stable and equal to the last completed result.
- R8: A `start` pulse while `done` is 0 is ignored. It changes neither the result nor the completion time.
- R9: The control word is ordered {load multiplicand, load multiplier, update accumulator, shift multiplier, clear accumulator}, from MSB to LSB. Its codes are 00000 when idle, 11001 in load and 00110 in each iteration. The load code clears the accumulator, so `product` reads 0 between the load edge and the first iteration edge.
- R10: Each iteration adds the multiplicand shifted left by the iteration index to the accumulator when the multiplier LSB is 1, and shifts the multiplier right by one bit.
- R11: A low `rst_n` during a multiply aborts it. The block returns to idle with `done` at 1 and `product` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiply; honoured only while idle |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| product | output | 2*WIDTH | Accumulator contents, the product once done |
| done | output | 1 | High while idle, low during a multiply |

## Verification
A 4-bit instance is swept over all 256 operand pairs. This separates errors in the add decision, which depends on the multiplier bits, from errors in the shift amount, which depends on the multiplicand position, and it includes the zero and all-ones rows. A 16-bit instance is given corner operands: all ones squared, single high bits, and zero and one on each side. These catch carry loss in the top half of the accumulator and an off-by-one in the iteration count. Some runs change the operands after capture or pulse `start` mid-operation, which separates a correct capture edge and a correct busy guard from designs that sample late or restart.

// File: rtl/shift_add_mul_pkg.sv
// Shared types for the shift-add multiplier.
// Assumes: the control word order is fixed; the datapath decodes fields by name.
package shift_add_mul_pkg;

    // Control word, MSB first: load A, load B, update acc, shift B, clear acc
    typedef struct packed {
        logic ld_a;
        logic ld_b;
        logic upd_acc;
        logic shf_b;
        logic clr_acc;
    } ctl_word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_ITER = 2'd2
    } mul_state_t;

    localparam ctl_word_t CW_IDLE = 5'b00000;
    localparam ctl_word_t CW_LOAD = 5'b11001;
    localparam ctl_word_t CW_ITER = 5'b00110;

endpackage

// File: rtl/shift_add_mul_ctrl.sv
// Control subsystem: three-state sequencer that issues one control word per
// register-transfer group and reports done while idle.
// Assumes: last_iter comes from the datapath counter and is valid in ST_ITER.
module shift_add_mul_ctrl
    import shift_add_mul_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      last_iter,
    output ctl_word_t cw,
    output logic      done
);

    mul_state_t state_q;
    mul_state_t state_d;

    // Next-state function
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_ITER;
            ST_ITER: if (last_iter) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output function: fixed control code per state
    always_comb begin
        case (state_q)
            ST_LOAD: cw = CW_LOAD;
            ST_ITER: cw = CW_ITER;
            default: cw = CW_IDLE;
        endcase
    end

    assign done = (state_q == ST_IDLE);

    AST_START_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_LOAD)); // R3
    AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_LOAD)); // R8
    AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER && last_iter) |=> done); // R6
    AST_LOAD_TO_ITER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (cw == CW_ITER)); // R9

endmodule

// File: rtl/shift_add_mul_dp.sv
// Data subsystem: multiplicand and multiplier registers, double-width
// accumulator and iteration counter, all steered by the control word.
// Assumes: WIDTH >= 2; the load code clears the counter together with the accumulator.
module shift_add_mul_dp
    import shift_add_mul_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctl_word_t          cw,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] acc,
    output logic               last_iter
);

    localparam int PW    = 2 * WIDTH;
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic [PW-1:0]    acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    addend;

    // Multiplicand aligned to the current iteration index
    assign addend = {{WIDTH{1'b0}}, a_q} << cnt_q;

    // Multiplicand register
    always_ff @(posedge clk) begin
        if (!rst_n)       a_q <= '0;
        else if (cw.ld_a) a_q <= op_a;
    end

    // Multiplier register: load or shift right
    always_ff @(posedge clk) begin
        if (!rst_n)        b_q <= '0;
        else if (cw.ld_b)  b_q <= op_b;
        else if (cw.shf_b) b_q <= b_q >> 1;
    end

    // Accumulator: clear, or conditionally add the aligned multiplicand
    always_ff @(posedge clk) begin
        if (!rst_n)                    acc_q <= '0;
        else if (cw.clr_acc)           acc_q <= '0;
        else if (cw.upd_acc && b_q[0]) acc_q <= acc_q + addend;
    end

    // Iteration counter: reset by load, advanced by each shift
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cw.ld_b)  cnt_q <= '0;
        else if (cw.shf_b) cnt_q <= cnt_q + 1'b1;
    end

    assign last_iter = (cnt_q == CNT_LAST);
    assign acc       = acc_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cw.clr_acc |=> (acc_q == '0)); // R9
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.shf_b && !cw.ld_b) |=> (b_q == ($past(b_q) >> 1))); // R10
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cw.upd_acc && !cw.clr_acc) |=> $stable(acc_q)); // R7
    AST_SKIP_ZERO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.upd_acc && !cw.clr_acc && !b_q[0]) |=> $stable(acc_q)); // R10

endmodule

// File: rtl/shift_add_mul.sv
// Top: connects the control subsystem to the data subsystem. The product
// port shows the accumulator at all times.
// Assumes: operands are held through the cycle after the accepted start.
module shift_add_mul
    import shift_add_mul_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product,
    output logic               done
);

    ctl_word_t cw;
    logic      last_iter;

    shift_add_mul_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_iter (last_iter),
        .cw        (cw),
        .done      (done)
    );

    shift_add_mul_dp #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cw        (cw),
        .op_a      (op_a),
        .op_b      (op_b),
        .acc       (product),
        .last_iter (last_iter)
    );

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product))); // R2
    AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done); // R3

endmodule

// File: tb/shift_add_mul_tb_top.sv
// Bench: an exhaustive sweep on a 4-bit instance and corner operands on a
// 16-bit instance, with every expected value computed arithmetically.
module shift_add_mul_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_s = 1'b0;
    logic        start_w = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [7:0]  prod_s;
    logic [31:0] prod_w;
    logic        done_s;
    logic        done_w;
    logic        sel_w = 1'b0;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    shift_add_mul #(.WIDTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start_s),
        .op_a(opa[3:0]), .op_b(opb[3:0]), .product(prod_s), .done(done_s)
    );

    shift_add_mul #(.WIDTH(16)) dut_w (
        .clk(clk), .rst_n(rst_n), .start(start_w),
        .op_a(opa), .op_b(opb), .product(prod_w), .done(done_w)
    );

    function automatic logic [31:0] cur_prod();
        return sel_w ? prod_w : {24'd0, prod_s};
    endfunction

    function automatic logic cur_done();
        return sel_w ? done_w : done_s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_start(input logic v);
        if (sel_w) start_w = v; else start_s = v;
    endtask

    // One multiply; optional operand change after capture and busy start pulse
    task automatic run_mul(input logic [15:0] a, input logic [15:0] b, input bit noisy);
        int w;
        int edges;
        logic [31:0] expv;
        logic [31:0] held;
        w = sel_w ? 16 : 4;
        expv = sel_w ? (32'(a) * 32'(b)) : 32'(a[3:0] * b[3:0]);
        @(negedge clk);
        opa = a; opb = b; set_start(1'b1);
        @(posedge clk);                       // accepting edge
        @(negedge clk);
        set_start(1'b0);
        check("R3", 32'(cur_done()), 32'd0);
        @(posedge clk);                       // load edge, operands captured
        @(negedge clk);
        check("R9", cur_prod(), 32'd0);
        if (noisy) begin opa = ~a; opb = ~b; end   // R4: late changes ignored
        edges = 1;
        while (cur_done() !== 1'b1 && edges < 40) begin
            if (noisy && edges == 2) set_start(1'b1);   // R8 busy start
            else set_start(1'b0);
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        set_start(1'b0);
        check(noisy ? "R6/R8" : "R6", 32'(edges), 32'(w + 1));
        check(noisy ? "R4/R5/R8" : "R5", cur_prod(), expv);
        held = cur_prod();
        repeat (2) @(negedge clk);
        check("R7", cur_prod(), held);
        check("R2", 32'(cur_done()), 32'd1);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", 32'(done_s), 32'd1);
        check("R1", 32'(prod_s), 32'd0);
        check("R1", 32'(done_w), 32'd1);
        check("R1", prod_w, 32'd0);

        // R5 R10: exhaustive 4-bit sweep
        sel_w = 1'b0;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_mul(16'(a), 16'(b), (a + b) % 7 == 3);
            end
        end

        // 16-bit corners
        sel_w = 1'b1;
        run_mul(16'hFFFF, 16'hFFFF, 1'b0);
        run_mul(16'h8000, 16'h8000, 1'b0);
        run_mul(16'h0000, 16'hBEEF, 1'b0);
        run_mul(16'h1234, 16'h0000, 1'b0);
        run_mul(16'h0001, 16'hA5A5, 1'b0);
        run_mul(16'hC3C3, 16'h0001, 1'b0);
        run_mul(16'hFFFF, 16'h8001, 1'b1);
        run_mul(16'h7FFF, 16'hFFFE, 1'b1);

        // R11: reset in the middle of a multiply
        @(negedge clk);
        opa = 16'hFFFF; opb = 16'hFFFF; start_w = 1'b1;
        @(negedge clk);
        start_w = 1'b0;
        repeat (6) @(negedge clk);
        check("R11", 32'(done_w), 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R11", 32'(done_w), 32'd1);
        check("R11", prod_w, 32'd0);
        repeat (3) @(negedge clk);
        check("R11", 32'(done_w), 32'd1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule